// File: doc/BRIEF.md
# Exception Entry Sequencer

This block steers a small 32-bit soft processor into and out of its exception handlers. When the core raises a one-cycle request with a 3-bit exception code and the program counter of the faulting instruction, the sequencer sorts the code into an ordinary or a debug class. It picks a vector base and emits the handler address. It also writes the return address into the right link register through a register-file write port, and it saves and clears the global interrupt enable. Two return operations put the saved enable back and redirect the PC to the address held in the matching link register. The register file supplies that address on a read input.

The sequencer owns six pieces of control state: the global enable, the two saved-enable bits, a remap bit and the two vector bases. All of them can be reached through a small control-register port with a combinational read. The core of the block is a state machine whose state records which operation was taken on the previous edge. State `ST_IDLE` is entered when nothing is accepted or only a control-register write happens. `ST_NORM_ENTRY` follows an accepted ordinary exception and `ST_DBG_ENTRY` follows an accepted debug exception. `ST_ERET` follows a return from exception and `ST_BRET` follows a return from breakpoint. `ST_BAD_IDX` follows a request that carries an unusable code. The next state depends only on the inputs of the current cycle, so any state can move to any other. Every state drives its outputs for exactly one cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the global enable, both saved enables and the remap bit read 0, both vector bases read 0, and `pc_load`, `rf_we` and `exc_illegal` are 0.
- R2: Codes are 3 bits wide. Codes 2 (instruction bus error), 4 (data bus error), 5 (divide by zero), 6 (interrupt) and 7 (system call) are ordinary. Codes 1 (breakpoint) and 3 (watchpoint) are debug. Code 0 (reset) is not accepted as an exception.
- R3: One cycle after an accepted ordinary exception, `pc_load` and `rf_we` are 1, `rf_waddr` is 30 (exception-return link register) and `rf_wdata` is the request's `exc_pc`.
- R4: One cycle after an accepted debug exception, `pc_load` and `rf_we` are 1, `rf_waddr` is 31 (breakpoint-return link register) and `rf_wdata` is the request's `exc_pc`.
- R5: On entry, the global enable is copied into the saved enable of the class (status bit 1 for ordinary, status bit 2 for debug) and the global enable (status bit 0) is cleared. The other class's saved enable is unchanged.
- R6: The handler address on `pc_next` is the chosen base plus the code multiplied by 32.
- R7: Ordinary exceptions use the normal base (control address 2) when the remap bit (control address 1, bit 0) is 0, and the debug base (control address 3) when it is 1.
- R8: Debug exceptions always use the debug base, whatever the remap bit holds.
- R9: A request with code 0 raises `exc_illegal` for one cycle in the next cycle. It keeps `pc_load` and `rf_we` at 0 and leaves every control register unchanged.
- R10: A return from exception copies status bit 1 into bit 0 and, one cycle later, loads `pc_next` with `ea_val`. A return from breakpoint copies status bit 2 into bit 0 and loads `ba_val`. Neither return writes the register file.
- R11: Control address 0 reads {29 zeros, saved debug enable, saved ordinary enable, global enable}. Address 1 reads the remap bit at bit 0. Addresses 2 and 3 read the normal and debug bases, with bits 7:0 always 0. Writes take effect on the next cycle, and reads are combinational.
- R12: Within one cycle the priority is exception request, then return from breakpoint, then return from exception, then control-register write. A lower-priority input that arrives with a higher one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_req | input | 1 | One-cycle exception request |
| exc_idx | input | 3 | Exception code |
| exc_pc | input | 32 | PC of the faulting instruction |
| eret_req | input | 1 | Return from exception |
| bret_req | input | 1 | Return from breakpoint |
| ea_val | input | 32 | Exception-return link register contents |
| ba_val | input | 32 | Breakpoint-return link register contents |
| csr_we | input | 1 | Control-register write enable |
| csr_addr | input | 2 | Control-register select |
| csr_wdata | input | 32 | Control-register write data |
| csr_rdata | output | 32 | Control-register read data |
| pc_load | output | 1 | Redirect the fetch PC |
| pc_next | output | 32 | New PC |
| rf_we | output | 1 | Link-register write enable |
| rf_waddr | output | 5 | Link-register number |
| rf_wdata | output | 32 | Return address to store |
| exc_illegal | output | 1 | Unusable exception code seen |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 3-bit code, 32-byte slots, bases aligned to 256 bytes and link registers 30 and 31. With these values every one of the eight codes lands inside one aligned vector table, so all codes, including the rejected one, can be driven against both bases with the remap bit on and off. The directed sequence also sets up each collision between entries, returns and control writes. A seeded pseudo-random stretch then mixes them freely, compared cycle by cycle with a behavioural model.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM_ENTRY,
        ST_DBG_ENTRY,
        ST_ERET,
        ST_BRET,
        ST_BAD_IDX
    } exc_state_e;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_NORMAL,
        CLS_DEBUG
    } exc_class_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ENTER_NORM,
        OP_ENTER_DBG,
        OP_RET_NORM,
        OP_RET_DBG,
        OP_CSR_WR
    } csr_op_e;

    typedef enum logic [1:0] {
        CSR_STATUS = 2'd0,
        CSR_DBGCTL = 2'd1,
        CSR_EBASE  = 2'd2,
        CSR_DBASE  = 2'd3
    } csr_sel_e;

    // Exception codes with special meaning; every other defined code is ordinary.
    localparam int unsigned CODE_RESET = 0;
    localparam int unsigned CODE_BREAK = 1;
    localparam int unsigned CODE_WATCH = 3;
    localparam int unsigned CODE_COUNT = 8;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_pkg::*;
#(
    parameter int unsigned IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    output exc_class_e       cls
);

    always_comb begin
        if (int'(idx) == CODE_RESET || int'(idx) >= CODE_COUNT) begin
            cls = CLS_NONE;
        end else if (int'(idx) == CODE_BREAK || int'(idx) == CODE_WATCH) begin
            cls = CLS_DEBUG;
        end else begin
            cls = CLS_NORMAL;
        end
    end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned IDX_W      = 3,
    parameter int unsigned SLOT_SHIFT = 5,
    parameter int unsigned BASE_LSB   = 8
) (
    input  logic [XLEN-1:BASE_LSB] base_hi,
    input  logic [IDX_W-1:0]       idx,
    output logic [XLEN-1:0]        vec
);

    localparam bit ALIGNED = (IDX_W + SLOT_SHIFT) <= BASE_LSB;

    logic [XLEN-1:0] base_full;
    logic [XLEN-1:0] slot_off;

    assign base_full = {base_hi, {BASE_LSB{1'b0}}};
    assign slot_off  = {{(XLEN-IDX_W){1'b0}}, idx} << SLOT_SHIFT;

    generate
        if (ALIGNED) begin : g_merge
            // The whole table fits below the base's zero bits: no carry chain.
            assign vec = base_full | slot_off;
        end else begin : g_add
            assign vec = base_full + slot_off;
        end
    endgenerate

endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
    import exc_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned BASE_LSB = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  csr_op_e                op,
    input  logic [1:0]             sel,
    input  logic [XLEN-1:0]        wdata,
    output logic [XLEN-1:0]        rdata,
    output logic                   ie,
    output logic                   eie,
    output logic                   bie,
    output logic                   remap,
    output logic [XLEN-1:BASE_LSB] eba_hi,
    output logic [XLEN-1:BASE_LSB] deba_hi
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie      <= 1'b0;
            eie     <= 1'b0;
            bie     <= 1'b0;
            remap   <= 1'b0;
            eba_hi  <= '0;
            deba_hi <= '0;
        end else begin
            unique case (op)
                OP_ENTER_NORM: begin
                    eie <= ie;
                    ie  <= 1'b0;
                end
                OP_ENTER_DBG: begin
                    bie <= ie;
                    ie  <= 1'b0;
                end
                OP_RET_NORM: ie <= eie;
                OP_RET_DBG:  ie <= bie;
                OP_CSR_WR: begin
                    unique case (csr_sel_e'(sel))
                        CSR_STATUS: begin
                            ie  <= wdata[0];
                            eie <= wdata[1];
                            bie <= wdata[2];
                        end
                        CSR_DBGCTL: remap   <= wdata[0];
                        CSR_EBASE:  eba_hi  <= wdata[XLEN-1:BASE_LSB];
                        CSR_DBASE:  deba_hi <= wdata[XLEN-1:BASE_LSB];
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (csr_sel_e'(sel))
            CSR_STATUS: rdata = {{(XLEN-3){1'b0}}, bie, eie, ie};
            CSR_DBGCTL: rdata = {{(XLEN-1){1'b0}}, remap};
            CSR_EBASE:  rdata = {eba_hi, {BASE_LSB{1'b0}}};
            CSR_DBASE:  rdata = {deba_hi, {BASE_LSB{1'b0}}};
        endcase
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned IDX_W      = 3,
    parameter int unsigned SLOT_SHIFT = 5,
    parameter int unsigned BASE_LSB   = 8,
    parameter int unsigned RF_AW      = 5,
    parameter int unsigned EA_REG     = 30,
    parameter int unsigned BA_REG     = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic [IDX_W-1:0] exc_idx,
    input  logic [XLEN-1:0]  exc_pc,
    input  logic             eret_req,
    input  logic             bret_req,
    input  logic [XLEN-1:0]  ea_val,
    input  logic [XLEN-1:0]  ba_val,
    input  logic             csr_we,
    input  logic [1:0]       csr_addr,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic [XLEN-1:0]  csr_rdata,
    output logic             pc_load,
    output logic [XLEN-1:0]  pc_next,
    output logic             rf_we,
    output logic [RF_AW-1:0] rf_waddr,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             exc_illegal
);

    localparam bit ALIGNED = (IDX_W + SLOT_SHIFT) <= BASE_LSB;
    localparam logic [RF_AW-1:0] EA_SEL = RF_AW'(EA_REG);
    localparam logic [RF_AW-1:0] BA_SEL = RF_AW'(BA_REG);

    exc_state_e state_q, state_d;
    csr_op_e    op;
    exc_class_e cls;

    logic                   ie, eie, bie, remap;
    logic [XLEN-1:BASE_LSB] eba_hi, deba_hi, sel_base;
    logic [XLEN-1:0]        vec;
    logic [XLEN-1:0]        tgt_q, link_q;

    exc_classify #(.IDX_W(IDX_W)) i_classify (
        .idx (exc_idx),
        .cls (cls)
    );

    assign sel_base = (cls == CLS_DEBUG || remap) ? deba_hi : eba_hi;

    exc_vector_gen #(
        .XLEN      (XLEN),
        .IDX_W     (IDX_W),
        .SLOT_SHIFT(SLOT_SHIFT),
        .BASE_LSB  (BASE_LSB)
    ) i_vector (
        .base_hi (sel_base),
        .idx     (exc_idx),
        .vec     (vec)
    );

    exc_csr_bank #(
        .XLEN    (XLEN),
        .BASE_LSB(BASE_LSB)
    ) i_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .sel     (csr_addr),
        .wdata   (csr_wdata),
        .rdata   (csr_rdata),
        .ie      (ie),
        .eie     (eie),
        .bie     (bie),
        .remap   (remap),
        .eba_hi  (eba_hi),
        .deba_hi (deba_hi)
    );

    // Accept at most one operation per cycle, in fixed priority order.
    always_comb begin
        op      = OP_NONE;
        state_d = ST_IDLE;
        if (exc_req) begin
            unique case (cls)
                CLS_NORMAL: begin
                    op      = OP_ENTER_NORM;
                    state_d = ST_NORM_ENTRY;
                end
                CLS_DEBUG: begin
                    op      = OP_ENTER_DBG;
                    state_d = ST_DBG_ENTRY;
                end
                default: state_d = ST_BAD_IDX;
            endcase
        end else if (bret_req) begin
            op      = OP_RET_DBG;
            state_d = ST_BRET;
        end else if (eret_req) begin
            op      = OP_RET_NORM;
            state_d = ST_ERET;
        end else if (csr_we) begin
            op = OP_CSR_WR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            link_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_d)
                ST_NORM_ENTRY, ST_DBG_ENTRY: begin
                    tgt_q  <= vec;
                    link_q <= exc_pc;
                end
                ST_ERET: tgt_q <= ea_val;
                ST_BRET: tgt_q <= ba_val;
                default: ;
            endcase
        end
    end

    always_comb begin
        pc_load     = 1'b0;
        rf_we       = 1'b0;
        rf_waddr    = EA_SEL;
        exc_illegal = 1'b0;
        unique case (state_q)
            ST_NORM_ENTRY: begin
                pc_load = 1'b1;
                rf_we   = 1'b1;
            end
            ST_DBG_ENTRY: begin
                pc_load  = 1'b1;
                rf_we    = 1'b1;
                rf_waddr = BA_SEL;
            end
            ST_ERET, ST_BRET: pc_load = 1'b1;
            ST_BAD_IDX:       exc_illegal = 1'b1;
            default: ;
        endcase
    end

    assign pc_next  = tgt_q;
    assign rf_wdata = link_q;

    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_illegal |-> (!pc_load && !rf_we));

    p_illegal_keeps_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_illegal |-> $stable({ie, eie, bie, remap}));

    p_entry_clears_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !ie);

    p_link_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (pc_load && (rf_waddr == EA_SEL || rf_waddr == BA_SEL)));

    p_eret_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_req && !exc_req && !bret_req) |=> (ie == $past(eie)));

    generate
        if (ALIGNED) begin : g_vec_chk
            p_debug_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (rf_we && rf_waddr == BA_SEL) |-> (pc_next[XLEN-1:BASE_LSB] == deba_hi));
        end
    endgenerate

endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [2:0]  exc_idx = '0;
    logic [31:0] exc_pc = '0;
    logic        eret_req = 1'b0;
    logic        bret_req = 1'b0;
    logic [31:0] ea_val = '0;
    logic [31:0] ba_val = '0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        pc_load;
    logic [31:0] pc_next;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        exc_illegal;

    always #10 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_idx(exc_idx), .exc_pc(exc_pc),
        .eret_req(eret_req), .bret_req(bret_req), .ea_val(ea_val), .ba_val(ba_val),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .pc_load(pc_load), .pc_next(pc_next), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .exc_illegal(exc_illegal)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Behavioural model state
    bit          m_ie = 0, m_eie = 0, m_bie = 0, m_re = 0;
    logic [31:0] m_eba = 0, m_deba = 0;
    bit          x_load = 0, x_we = 0, x_ill = 0;
    logic [31:0] x_pc = 0, x_data = 0;
    logic [4:0]  x_addr = 0;
    string       t_out = "R1", t_pc = "R1", t_csr = "R1", t_addr = "R1";

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [1:0] a);
        case (a)
            2'd0:    return {29'd0, m_bie, m_eie, m_ie};
            2'd1:    return {31'd0, m_re};
            2'd2:    return m_eba;
            default: return m_deba;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        x_load = 0; x_we = 0; x_ill = 0;
        if (!rst_n) begin
            m_ie = 0; m_eie = 0; m_bie = 0; m_re = 0; m_eba = 0; m_deba = 0;
            t_out = "R1"; t_pc = "R1"; t_csr = "R1"; t_addr = "R1";
        end else begin
            t_out = "R11"; t_csr = "R11";
            if (exc_req) begin
                if (eret_req || bret_req || csr_we) t_csr = "R12";
                if (exc_idx == 0) begin
                    x_ill = 1; t_out = "R9"; t_csr = "R9";
                end else begin
                    bit dbg;
                    dbg = (exc_idx == 1 || exc_idx == 3);
                    x_load = 1; x_we = 1;
                    x_pc   = ((dbg || m_re) ? m_deba : m_eba) + 32 * exc_idx;
                    x_addr = dbg ? 5'd31 : 5'd30;
                    x_data = exc_pc;
                    t_out  = dbg ? "R4" : "R3";
                    t_addr = "R2";
                    t_pc   = dbg ? "R8" : (m_re ? "R7" : "R6");
                    if (dbg) m_bie = m_ie; else m_eie = m_ie;
                    m_ie = 0;
                    if (t_csr != "R12") t_csr = "R5";
                end
            end else if (bret_req) begin
                x_load = 1; x_pc = ba_val; m_ie = m_bie;
                t_out = "R10"; t_pc = "R10"; t_csr = (eret_req || csr_we) ? "R12" : "R10";
            end else if (eret_req) begin
                x_load = 1; x_pc = ea_val; m_ie = m_eie;
                t_out = "R10"; t_pc = "R10"; t_csr = csr_we ? "R12" : "R10";
            end else if (csr_we) begin
                case (csr_addr)
                    2'd0: begin m_ie = csr_wdata[0]; m_eie = csr_wdata[1]; m_bie = csr_wdata[2]; end
                    2'd1: m_re = csr_wdata[0];
                    2'd2: m_eba = {csr_wdata[31:8], 8'd0};
                    default: m_deba = {csr_wdata[31:8], 8'd0};
                endcase
            end
        end
    end

    always @(negedge clk) begin
        chk(t_out, "pc_load", 32'(pc_load), 32'(x_load));
        chk(t_out, "rf_we", 32'(rf_we), 32'(x_we));
        chk(t_out == "R1" ? "R1" : "R9", "exc_illegal", 32'(exc_illegal), 32'(x_ill));
        if (x_load) chk(t_pc, "pc_next", pc_next, x_pc);
        if (x_we) begin
            chk(t_addr, "rf_waddr", 32'(rf_waddr), 32'(x_addr));
            chk(t_out, "rf_wdata", rf_wdata, x_data);
        end
        chk(t_csr, "csr_rdata", csr_rdata, model_read(csr_addr));
    end

    logic [1:0] rot = 0;

    task automatic step(bit er = 0, logic [2:0] ix = 0, logic [31:0] pc = 0,
                        bit ret_e = 0, bit ret_b = 0, bit we = 0,
                        logic [1:0] a = 0, logic [31:0] wd = 0, bit use_a = 0);
        exc_req = er; exc_idx = ix; exc_pc = pc;
        eret_req = ret_e; bret_req = ret_b;
        csr_we = we; csr_wdata = wd;
        csr_addr = (we || use_a) ? a : rot;
        rot = rot + 1;
        ea_val = pc ^ 32'h0000_1004;
        ba_val = pc ^ 32'h0000_2008;
        @(posedge clk); #2;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        lf = 32'hACE1_2357;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step(); step(); step(); step();                            // R1 reset values read back
        step(0,0,0,0,0,1,2'd2,32'h1234_5678);                      // R11 base low bits drop
        step(0,0,0,0,0,1,2'd3,32'hABCD_EFFF);
        step(0,0,0,0,0,1,2'd0,32'h0000_0001);
        step(); step();
        step(1,3'd6,32'h0000_0100);                                // R3 R6 ordinary entry
        step(); step(0,0,32'h104,1); step();                       // R10 eret
        step(1,3'd1,32'h0000_0200);                                // R4 R8 breakpoint
        step(); step(0,0,32'h204,0,1); step();                     // R10 bret
        step(0,0,0,0,0,1,2'd0,32'h0000_0004);
        step(1,3'd3,32'h0000_0300); step();                        // R5 watchpoint, IE 0
        step(0,0,0,0,0,1,2'd1,32'h1);                              // R7 remap on
        step(0,0,0,0,0,1,2'd0,32'h7);
        step(1,3'd2,32'h0000_0400); step();
        step(1,3'd7,32'h0000_0500); step();
        step(1,3'd1,32'h0000_0600); step();                        // R8 with remap
        step(0,0,0,0,0,1,2'd0,32'h3);
        step(1,3'd0,32'h0000_0700,0,0,0,2'd0,0,1); step();         // R9 illegal code
        step(1,3'd4,32'h0000_0800,1,1,1,2'd0,32'h0,0); step();     // R12 all at once
        step(0,0,32'h900,1,1,1,2'd0,32'h0); step();                // R12 bret over eret
        step(0,0,32'hA00,1,0,1,2'd1,32'h0); step();                // R12 eret over write
        step(1,3'd0,32'hB00,0,0,1,2'd2,32'hFFFF_FFFF); step();     // R9 R12 illegal blocks write
        for (int i = 0; i < 600; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[0] & lf[1], lf[4:2], {lf[31:8], 8'h00}, lf[5] & lf[6] & lf[7],
                 lf[8] & lf[9] & lf[10], lf[11], lf[13:12], lf ^ 32'h5A5A_0000, lf[14]);
        end
        step(); step();
        finish_run();
    end

endmodule